// File: doc/BRIEF.md
# Forced Link Speed Fallback Controller

This block brings an Ethernet PHY's link up without IEEE auto-negotiation. On a start pulse it resets the PHY through its management registers. It then forces the PHY to 100 Mb/s and watches link status at a fixed check interval. If no link shows up after a set number of checks, it resets the PHY again and forces 10 Mb/s. If that attempt also fails, it emits a one-cycle request for the system to reinitialise the interface, and then goes idle.

All PHY accesses go through a request/response handshake to an external management-bus master. A request is a read or write of one 16-bit register. The master accepts it with `req_ready` and signals completion with `rsp_valid`, which also carries the read data. Only one access is outstanding at a time. The PHY-reset poll spacing and the link-check interval both come from cycle counters, so the block needs no external timer.

Top module: `link_fallback_ctrl`

## Requirements
- R1: After reset, `link_up`, `speed_100`, `reset_err` and `reinit` are 0 and `req_valid` is 0.
- R2: A `start` pulse while idle begins a PHY reset. Two writes go to the control register (address 0): first 0x4C00, which sets loopback bit 14, power-down bit 11 and isolate bit 10. Second, 0x8000, which sets only the reset bit 15.
- R3: After the reset write, the control register is read repeatedly until bit 15 reads 0. Consecutive reads are spaced at least POLL_CYCLES apart. There are at most MAX_POLLS reads. If every one of them shows bit 15 set, `reset_err` rises and stays at 1 until the next start, and the sequence carries on.
- R4: Once the reset is over, the control register is read once more and written back. On the first attempt bit 13 is set (100 Mb/s). On the fallback attempt bit 13 is cleared (10 Mb/s).
- R5: Each link check reads the status register (address 1) and then the control register. A check begins no sooner than CHECK_CYCLES after the speed write completes, or after the previous check.
- R6: If status bit 2 is set in a check, the block raises `link_up`, sets `speed_100` to bit 13 of that check's control read, and issues no further requests.
- R7: After FAIL_CHECKS checks without link whose control read has bit 13 set, the block repeats the reset of R2/R3 and then forces 10 Mb/s per R4.
- R8: After FAIL_CHECKS checks without link whose control read has bit 13 clear, `reinit` pulses for exactly one cycle, `link_up` stays 0, and the block stops.
- R9: While stopped (before start, linked, or given up), elapsed check intervals issue no requests and change no output. The check count starts from zero at every new start.
- R10: While `req_valid` is high and `req_ready` is low, `req_write`, `req_addr` and `req_wdata` hold steady. No new request is raised until `rsp_valid` completes the previous one.
- R11: A `start` pulse that arrives while a sequence is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a bring-up sequence (ignored while busy) |
| req_valid | output | 1 | Register access request pending |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 5 | PHY register address |
| req_wdata | output | 16 | Write data |
| req_ready | input | 1 | Master accepts the request this cycle |
| rsp_valid | input | 1 | Access complete; read data valid |
| rsp_rdata | input | 16 | Read data |
| link_up | output | 1 | Link established |
| speed_100 | output | 1 | Forced speed at link-up: 1 = 100 Mb/s |
| reset_err | output | 1 | PHY reset bit never cleared within the poll limit |
| reinit | output | 1 | One-cycle request to reinitialise after both speeds failed |

## Verification
The bench targets several corner cases, each of which a specific design fault would break:
- A reset that clears on the last allowed poll and one that never clears: a design with an off-by-one poll limit either flags an error that should not be raised, or issues a 65th read.
- Link appearing on the fourth check, which is the last allowed: a design that gives up one check early falls back or asks for reinitialisation needlessly.
- Fallback to 10 Mb/s: a design that forgot to clear bit 13 or to reset the check count would write the wrong control word, or fall back after the wrong number of checks.
- Quiet periods after link-up and after giving up, and stray start pulses mid-sequence: these expose a timer that keeps issuing status reads while stopped, or a sequence that restarts part-way.

// File: rtl/lfb_pkg.sv
package lfb_pkg;
    localparam logic [4:0] CTRL_REG_ADDR = 5'd0;
    localparam logic [4:0] STAT_REG_ADDR = 5'd1;

    localparam int BIT_RESET = 15;
    localparam int BIT_LOOP  = 14;
    localparam int BIT_SPEED = 13;
    localparam int BIT_PDOWN = 11;
    localparam int BIT_ISO   = 10;
    localparam int BIT_LINK  = 2;

    localparam logic [15:0] QUIESCE_WORD = (16'd1 << BIT_LOOP) | (16'd1 << BIT_PDOWN) | (16'd1 << BIT_ISO);
    localparam logic [15:0] RESET_WORD   = 16'd1 << BIT_RESET;
    localparam logic [15:0] SPEED_MASK   = 16'd1 << BIT_SPEED;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_QUIESCE_WR,
        ST_RESET_WR,
        ST_POLL_RD,
        ST_POLL_GAP,
        ST_BACK_RD,
        ST_SPEED_WR,
        ST_CHECK_WAIT,
        ST_STAT_RD,
        ST_CTRL_RD
    } lfb_state_e;
endpackage

// File: rtl/lfb_interval.sv
module lfb_interval #(
    parameter int LIMIT = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic due
);
    localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

    logic [W-1:0] count_d, count_q;

    always_comb begin
        count_d = arm ? count_q + 1'b1 : '0;
        due     = arm && (count_q == W'(LIMIT - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    a_r5_count_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        arm |-> (count_q <= W'(LIMIT - 1)));
endmodule

// File: rtl/lfb_req_drive.sv
module lfb_req_drive
    import lfb_pkg::*;
(
    input  lfb_state_e  state,
    input  logic        issued,
    input  logic [15:0] speed_word,
    output logic        req_valid,
    output logic        req_write,
    output logic [4:0]  req_addr,
    output logic [15:0] req_wdata
);
    logic is_access;

    always_comb begin
        is_access = 1'b0;
        req_write = 1'b0;
        req_addr  = CTRL_REG_ADDR;
        req_wdata = '0;
        unique case (state)
            ST_QUIESCE_WR: begin is_access = 1'b1; req_write = 1'b1; req_wdata = QUIESCE_WORD; end
            ST_RESET_WR:   begin is_access = 1'b1; req_write = 1'b1; req_wdata = RESET_WORD;   end
            ST_SPEED_WR:   begin is_access = 1'b1; req_write = 1'b1; req_wdata = speed_word;   end
            ST_POLL_RD, ST_BACK_RD, ST_CTRL_RD: is_access = 1'b1;
            ST_STAT_RD:    begin is_access = 1'b1; req_addr = STAT_REG_ADDR; end
            default: ;
        endcase
        req_valid = is_access && !issued;
    end
endmodule

// File: rtl/link_fallback_ctrl.sv
module link_fallback_ctrl
    import lfb_pkg::*;
#(
    parameter int CHECK_CYCLES = 240_000_000,
    parameter int POLL_CYCLES  = 4000,
    parameter int MAX_POLLS    = 64,
    parameter int FAIL_CHECKS  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output logic        req_valid,
    output logic        req_write,
    output logic [4:0]  req_addr,
    output logic [15:0] req_wdata,
    input  logic        req_ready,
    input  logic        rsp_valid,
    input  logic [15:0] rsp_rdata,
    output logic        link_up,
    output logic        speed_100,
    output logic        reset_err,
    output logic        reinit
);
    localparam int PW = $clog2(MAX_POLLS + 1);
    localparam int CW = $clog2(FAIL_CHECKS + 1);

    typedef struct packed {
        lfb_state_e     st;
        logic           issued;
        logic [PW-1:0]  polls;
        logic [CW-1:0]  checks;
        logic           try10;
        logic           saw_link;
        logic [15:0]    word;
        logic           link;
        logic           spd;
        logic           err;
        logic           pulse;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic gap_due, chk_due, done;

    lfb_interval #(.LIMIT(POLL_CYCLES)) u_poll_gap (
        .clk(clk), .rst_n(rst_n), .arm(ctl_q.st == ST_POLL_GAP), .due(gap_due));

    lfb_interval #(.LIMIT(CHECK_CYCLES)) u_check_gap (
        .clk(clk), .rst_n(rst_n), .arm(ctl_q.st == ST_CHECK_WAIT), .due(chk_due));

    lfb_req_drive u_req (
        .state(ctl_q.st), .issued(ctl_q.issued), .speed_word(ctl_q.word),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata));

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.pulse = 1'b0;
        done        = rsp_valid && ctl_q.issued;
        if (req_valid && req_ready) ctl_d.issued = 1'b1;
        if (done)                   ctl_d.issued = 1'b0;

        unique case (ctl_q.st)
            ST_IDLE: begin
                ctl_d.checks = '0;
                if (start) begin
                    ctl_d.st     = ST_QUIESCE_WR;
                    ctl_d.issued = 1'b0;
                    ctl_d.try10  = 1'b0;
                    ctl_d.link   = 1'b0;
                    ctl_d.spd    = 1'b0;
                    ctl_d.err    = 1'b0;
                end
            end
            ST_QUIESCE_WR: if (done) ctl_d.st = ST_RESET_WR;
            ST_RESET_WR: if (done) begin
                ctl_d.st    = ST_POLL_RD;
                ctl_d.polls = '0;
            end
            ST_POLL_RD: if (done) begin
                ctl_d.polls = ctl_q.polls + 1'b1;
                if (!rsp_rdata[BIT_RESET]) begin
                    ctl_d.st = ST_BACK_RD;
                end else if (ctl_q.polls == PW'(MAX_POLLS - 1)) begin
                    ctl_d.err = 1'b1;
                    ctl_d.st  = ST_BACK_RD;
                end else begin
                    ctl_d.st = ST_POLL_GAP;
                end
            end
            ST_POLL_GAP: if (gap_due) ctl_d.st = ST_POLL_RD;
            ST_BACK_RD: if (done) begin
                ctl_d.word = ctl_q.try10 ? (rsp_rdata & ~SPEED_MASK) : (rsp_rdata | SPEED_MASK);
                ctl_d.st   = ST_SPEED_WR;
            end
            ST_SPEED_WR: if (done) begin
                ctl_d.st     = ST_CHECK_WAIT;
                ctl_d.checks = '0;
            end
            ST_CHECK_WAIT: if (chk_due) ctl_d.st = ST_STAT_RD;
            ST_STAT_RD: if (done) begin
                ctl_d.saw_link = rsp_rdata[BIT_LINK];
                ctl_d.st       = ST_CTRL_RD;
            end
            ST_CTRL_RD: if (done) begin
                if (ctl_q.saw_link) begin
                    ctl_d.link = 1'b1;
                    ctl_d.spd  = rsp_rdata[BIT_SPEED];
                    ctl_d.st   = ST_IDLE;
                end else if (ctl_q.checks == CW'(FAIL_CHECKS - 1)) begin
                    ctl_d.checks = '0;
                    if (rsp_rdata[BIT_SPEED]) begin
                        ctl_d.try10 = 1'b1;
                        ctl_d.st    = ST_QUIESCE_WR;
                    end else begin
                        ctl_d.pulse = 1'b1;
                        ctl_d.st    = ST_IDLE;
                    end
                end else begin
                    ctl_d.checks = ctl_q.checks + 1'b1;
                    ctl_d.st     = ST_CHECK_WAIT;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q          <= '0;
            ctl_q.st       <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign link_up   = ctl_q.link;
    assign speed_100 = ctl_q.spd;
    assign reset_err = ctl_q.err;
    assign reinit    = ctl_q.pulse;

    a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_write) && $stable(req_addr) && $stable(req_wdata)));
    a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_valid);
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reinit |=> !reinit);
    a_r8_no_link_on_giveup: assert property (@(posedge clk) disable iff (!rst_n)
        reinit |-> !link_up);
    a_r6_quiet_when_linked: assert property (@(posedge clk) disable iff (!rst_n)
        link_up |-> !req_valid);
    a_r3_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.polls <= PW'(MAX_POLLS));
    a_r7_check_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.checks < CW'(FAIL_CHECKS));
endmodule

// File: tb/link_fallback_ctrl_tb.sv
`timescale 1ns/1ps
module link_fallback_ctrl_tb;
    localparam int CHECK = 200;
    localparam int POLL  = 10;
    localparam int NEVER = 99;
    localparam int DEFW  = 'h3100;

    logic clk = 0, rst_n = 0, start = 0;
    logic req_valid, req_write, req_ready = 0, rsp_valid = 0;
    logic [4:0] req_addr;
    logic [15:0] req_wdata, rsp_rdata = 0;
    logic link_up, speed_100, reset_err, reinit;

    always #2.5 clk = ~clk;

    link_fallback_ctrl #(.CHECK_CYCLES(CHECK), .POLL_CYCLES(POLL), .MAX_POLLS(64), .FAIL_CHECKS(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .link_up(link_up), .speed_100(speed_100), .reset_err(reset_err), .reinit(reinit));

    int n_chk = 0, n_bad = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // PHY model and scenario knobs
    int sc_np1, sc_np2, sc_t100, sc_t10;
    int m_ctrl, m_pend, m_resets, m_stat;
    int log_n, hold_viol, reinit_cnt, pulse_viol;
    int log_wr[256], log_addr[256], log_wd[256], log_rd[256], log_cyc[256];
    int exp_n, exp_link, exp_spd, exp_err, exp_reinit;
    int exp_wr[256], exp_addr[256], exp_wd[256];

    task automatic check(input string req, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    function automatic int model_access(input int wr, input int addr, input int wd);
        int r = 0;
        if (wr) begin
            if (wd[15]) begin
                m_pend = (m_resets == 0) ? sc_np1 : sc_np2;
                m_resets++;
                m_ctrl = DEFW;
            end else m_ctrl = wd;
            m_stat = 0;
        end else if (addr == 0) begin
            r = m_ctrl;
            if (m_pend > 0) begin m_pend--; r = r | 'h8000; end
        end else begin
            int thr = m_ctrl[13] ? sc_t100 : sc_t10;
            r = 'h7809 | ((m_stat >= thr) ? 4 : 0);
            m_stat++;
        end
        return r;
    endfunction

    // responder: management-bus master stand-in
    initial begin
        int busy = 0, lat = 0, pend = 0;
        logic pv = 0, pr = 0, pw = 0;
        logic [4:0] pa = 0;
        logic [15:0] pd = 0;
        forever begin
            @(negedge clk);
            if (pv && !pr && !(req_valid && req_write == pw && req_addr == pa && req_wdata == pd))
                hold_viol++;
            rsp_valid = 0;
            req_ready = 0;
            if (busy) begin
                lat--;
                if (lat == 0) begin rsp_valid = 1; rsp_rdata = pend[15:0]; busy = 0; end
            end else if (req_valid && ($urandom % 4 != 0)) begin
                req_ready = 1;
                log_wr[log_n] = req_write; log_addr[log_n] = req_addr;
                log_wd[log_n] = req_wdata; log_cyc[log_n] = cyc;
                pend = model_access(req_write, req_addr, req_wdata);
                log_rd[log_n] = pend;
                if (log_n < 255) log_n++;
                busy = 1; lat = 1 + $urandom % 3;
            end
            pv = req_valid; pr = req_ready; pw = req_write; pa = req_addr; pd = req_wdata;
        end
    end

    initial begin
        logic prev = 0;
        forever begin
            @(negedge clk);
            if (reinit && prev) pulse_viol++;
            if (reinit && !prev) reinit_cnt++;
            prev = reinit;
        end
    end

    task automatic push(input int w, input int a, input int d);
        exp_wr[exp_n] = w; exp_addr[exp_n] = a; exp_wd[exp_n] = d; exp_n++;
    endtask

    task automatic build_expected();
        exp_n = 0; exp_link = 0; exp_spd = 0; exp_err = 0; exp_reinit = 0;
        for (int ph = 0; ph < 2; ph++) begin
            int np  = ph ? sc_np2 : sc_np1;
            int thr = ph ? sc_t10 : sc_t100;
            int k;
            push(1, 0, 'h4C00); push(1, 0, 'h8000);                     // R2
            if (np >= 64) begin for (int i = 0; i < 64; i++) push(0, 0, 0); exp_err = 1; end
            else for (int i = 0; i <= np; i++) push(0, 0, 0);            // R3
            push(0, 0, 0); push(1, 0, ph ? 'h1100 : 'h3100);            // R4
            k = (thr < 4) ? thr + 1 : 4;
            for (int i = 0; i < k; i++) begin push(0, 1, 0); push(0, 0, 0); end // R5
            if (thr < 4) begin exp_link = 1; exp_spd = !ph; return; end  // R6
            if (ph == 1) exp_reinit = 1;                                 // R8, R7 otherwise
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
    endtask

    task automatic run_scn(input int np1, input int np2, input int t100, input int t10, input int spam);
        int w = 0, mism = -1, n_end, l_end, s_end, gap_bad = 0, set_run = 0, anchor = 0;
        sc_np1 = np1; sc_np2 = np2; sc_t100 = t100; sc_t10 = t10;
        m_ctrl = DEFW; m_pend = 0; m_resets = 0; m_stat = 0;
        log_n = 0; hold_viol = 0; reinit_cnt = 0; pulse_viol = 0;
        build_expected();
        pulse_start();
        if (spam) begin                                                 // R11
            repeat (20) @(negedge clk); pulse_start();
            repeat (100) @(negedge clk); pulse_start();
        end
        while (!link_up && reinit_cnt == 0 && w < 20000) begin @(negedge clk); w++; end
        check("R6/R8 sequence ends", (w < 20000), 1);
        n_end = log_n; l_end = link_up; s_end = speed_100;
        repeat (3 * CHECK) @(negedge clk);
        check("R9 no requests while stopped", log_n, n_end);
        check("R9 outputs hold while stopped", {l_end[0], s_end[0]}, {link_up, speed_100});
        for (int i = 0; i < exp_n && i < log_n; i++)
            if (mism < 0 && (log_wr[i] != exp_wr[i] || log_addr[i] != exp_addr[i] ||
                             (exp_wr[i] != 0 && log_wd[i] != exp_wd[i]))) mism = i;
        check("R2/R3/R4/R5/R7 access count", log_n, exp_n);
        if (mism >= 0)
            check("R2/R4/R7 access content", {log_wr[mism][3:0], log_addr[mism][3:0], log_wd[mism][15:0]},
                  {exp_wr[mism][3:0], exp_addr[mism][3:0], exp_wd[mism][15:0]});
        else check("R2/R4/R7 access content", 0, 0);
        for (int i = 0; i < log_n; i++) begin
            if (i > 0 && !log_wr[i] && log_addr[i] == 0 && !log_wr[i-1] && log_addr[i-1] == 0
                && log_rd[i-1][15] && set_run < 64 && log_cyc[i] - log_cyc[i-1] < POLL) gap_bad++;
            if (!log_wr[i] && log_addr[i] == 0 && log_rd[i][15]) set_run++; else if (!log_wr[i] && log_addr[i] == 0) set_run = 0;
            if (!log_wr[i] && log_addr[i] == 1) begin
                if (log_cyc[i] - anchor < CHECK) gap_bad++;
                anchor = log_cyc[i];
            end
            if (log_wr[i]) begin anchor = log_cyc[i]; set_run = 0; end
        end
        check("R3/R5 access spacing violations", gap_bad, 0);
        check("R6 link_up", link_up, exp_link);
        check("R6 speed_100", speed_100, exp_spd);
        check("R3 reset_err", reset_err, exp_err);
        check("R8 reinit pulses", reinit_cnt, exp_reinit);
        check("R8 reinit width", pulse_viol, 0);
        check("R10 request hold", hold_viol, 0);
    endtask

    function automatic int pick_thr();
        int v = $urandom % 5;
        return (v == 4) ? NEVER : v;
    endfunction

    initial begin
        void'($urandom(32'd20241));
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset outputs", {link_up, speed_100, reset_err, reinit, req_valid}, 0);
        log_n = 0;
        repeat (3 * CHECK) @(negedge clk);
        check("R9 idle before start issues nothing", log_n, 0);

        run_scn(2, 0, 0, 0, 0);            // R6 link at first 100 Mb/s check
        run_scn(0, 0, 3, 0, 0);            // R5 link on last allowed check
        run_scn(1, 2, NEVER, 1, 0);        // R7 fallback, link at 10 Mb/s
        run_scn(0, 0, NEVER, NEVER, 0);    // R8 give up
        run_scn(64, 0, 0, 0, 0);           // R3 reset never clears
        run_scn(63, 0, 0, 0, 0);           // R3 clears on last poll
        run_scn(3, 64, NEVER, 2, 1);       // R11 stray starts, R3 on second reset
        run_scn(0, 0, NEVER, 3, 0);        // R9 fresh count after restart
        for (int i = 0; i < 6; i++)
            run_scn($urandom % 6, $urandom % 6, pick_thr(), pick_thr(), $urandom % 2);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule